// File: doc/BRIEF.md
# Paged Pointer Effective-Address Unit

This block holds the address state of a small controller: a 16-bit program counter and three 16-bit general pointers. It forms the memory address for each access by adding a signed byte offset to the selected pointer. The sum is confined to a 4 KiB page. The low 12 bits wrap around, and the top 4 bits are always copied from the pointer, so they act as a fixed page number. Program-counter stepping follows the same page-wrap rule.

The surrounding core drives one-cycle operation strobes. The block can write the computed address back into the pointer (auto-indexing), trade a byte between the accumulator and one half of a pointer, or exchange a whole pointer with the program counter. That exchange gives a one-level call and return. The effective address and the byte leaving the pointer appear combinationally in the same cycle. Register updates take effect at the next rising clock edge.

Top module: `ptr_page_eau`

## Requirements
- R1: While `rst_n` is low, all four pointers are cleared to 0x0000 at the clock edge.
- R2: `ptr_sel` picks the pointer: 0 is the program counter and 1 to 3 are the general pointers. `ea_o` is the selected pointer plus the sign-extended `disp_i`. The 12-bit low part wraps modulo 4096, and `ea_o[15:12]` always equals the pointer's bits 15:12 (0x1FF0 + 0x20 gives 0x1010; 0x1005 - 16 gives 0x1FF5).
- R3: When `disp_i` is 0x80, the signed value of `ext_i` is used as the offset instead of `disp_i`.
- R4: A program-counter step adds 1 to bits 11:0 with the same wrap and keeps bits 15:12 (0x2FFF steps to 0x2000).
- R5: With auto-indexing and a negative offset, `ea_o` is the new address, and the pointer takes that address at the edge.
- R6: With auto-indexing and an offset of zero or more, `ea_o` is the old pointer value, and the pointer takes the sum at the edge.
- R7: `acc_o` always shows the high byte (`byte_hi_i`=1, bits 15:8) or the low byte (`byte_hi_i`=0, bits 7:0) of the selected pointer. A byte swap writes `acc_i` into that byte at the edge.
- R8: An exchange swaps the selected pointer and the program counter in one edge. With `ptr_sel`=0 nothing changes.
- R9: When several strobes are high, only one acts. The order is exchange, then byte swap, then auto-index, then step.
- R10: With no strobe high, all four pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ptr_sel | input | 2 | Pointer select (0 = program counter) |
| disp_i | input | 8 | Signed displacement; 0x80 selects `ext_i` |
| ext_i | input | 8 | Run-time signed offset |
| acc_i | input | 8 | Accumulator byte for byte swap |
| xchg_pc_i | input | 1 | Exchange selected pointer with program counter |
| xchg_byte_i | input | 1 | Byte swap between accumulator and pointer |
| byte_hi_i | input | 1 | Byte swap half: 1 high, 0 low |
| auto_idx_i | input | 1 | Write effective address back to pointer |
| pc_inc_i | input | 1 | Step program counter |
| ea_o | output | 16 | Memory address for this cycle |
| acc_o | output | 8 | Pointer byte leaving toward the accumulator |
| pc_o | output | 16 | Program counter |
| p1_o | output | 16 | General pointer 1 |
| p2_o | output | 16 | General pointer 2 |
| p3_o | output | 16 | General pointer 3 |

## Verification
A pointer that holds a wrong value shows up in the very next cycle. It appears on its own output port, and also on `ea_o` and `acc_o` whenever that pointer is selected. A carry that leaks into the page bits therefore surfaces either at once on `ea_o` or one edge later on the written-back pointer. The bench keeps a behavioural model of all four pointers and compares every output in every cycle. Directed cases cover both wrap directions, the extension-offset escape and strobe collisions before a long random run.

// File: rtl/ptr_page_eau_pkg.sv
package ptr_page_eau_pkg;
    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 12;
    localparam int BYTE_W  = 8;
    localparam int NUM_PTR = 4;
    localparam int SEL_W   = $clog2(NUM_PTR);

    typedef logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_arr_t;

    typedef struct packed {
        ptr_arr_t ptr;
    } regs_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_XPC,
        OP_XBYTE,
        OP_AUTO,
        OP_INC
    } op_t;
endpackage

// File: rtl/ptr_page_adder.sv
module ptr_page_adder #(
    parameter int AW = 16,
    parameter int PW = 12,
    parameter int OW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] off_i,
    output logic [AW-1:0] sum_o
);
    localparam int EXT_W = PW - OW;

    logic [PW-1:0] off_ext;
    logic [PW-1:0] low_sum;

    assign off_ext = {{EXT_W{off_i[OW-1]}}, off_i};
    assign low_sum = base_i[PW-1:0] + off_ext;
    assign sum_o   = {base_i[AW-1:PW], low_sum};
endmodule

// File: rtl/ptr_offset_pick.sv
module ptr_offset_pick #(
    parameter int OW = 8
) (
    input  logic [OW-1:0] disp_i,
    input  logic [OW-1:0] ext_i,
    output logic [OW-1:0] off_o
);
    localparam logic [OW-1:0] ESCAPE = {1'b1, {(OW-1){1'b0}}};

    assign off_o = (disp_i == ESCAPE) ? ext_i : disp_i;
endmodule

// File: rtl/ptr_op_arbiter.sv
module ptr_op_arbiter
    import ptr_page_eau_pkg::*;
(
    input  logic xchg_pc_i,
    input  logic xchg_byte_i,
    input  logic auto_idx_i,
    input  logic pc_inc_i,
    output op_t  op_o
);
    always_comb begin
        if (xchg_pc_i)        op_o = OP_XPC;
        else if (xchg_byte_i) op_o = OP_XBYTE;
        else if (auto_idx_i)  op_o = OP_AUTO;
        else if (pc_inc_i)    op_o = OP_INC;
        else                  op_o = OP_NONE;
    end
endmodule

// File: rtl/ptr_page_eau.sv
module ptr_page_eau
    import ptr_page_eau_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     ptr_sel,
    input  logic [BYTE_W-1:0]    disp_i,
    input  logic [BYTE_W-1:0]    ext_i,
    input  logic [BYTE_W-1:0]    acc_i,
    input  logic                 xchg_pc_i,
    input  logic                 xchg_byte_i,
    input  logic                 byte_hi_i,
    input  logic                 auto_idx_i,
    input  logic                 pc_inc_i,
    output logic [ADDR_W-1:0]    ea_o,
    output logic [BYTE_W-1:0]    acc_o,
    output logic [ADDR_W-1:0]    pc_o,
    output logic [ADDR_W-1:0]    p1_o,
    output logic [ADDR_W-1:0]    p2_o,
    output logic [ADDR_W-1:0]    p3_o
);
    localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

    regs_t               st_q, st_d;
    op_t                 op;
    logic [BYTE_W-1:0]   off;
    logic [ADDR_W-1:0]   sel_val;
    logic [ADDR_W-1:0]   ea_sum;
    logic [ADDR_W-1:0]   pc_step;
    logic                post_mode;

    assign sel_val = st_q.ptr[ptr_sel];

    ptr_offset_pick #(.OW(BYTE_W)) u_off (
        .disp_i (disp_i),
        .ext_i  (ext_i),
        .off_o  (off)
    );

    ptr_page_adder #(.AW(ADDR_W), .PW(PAGE_W), .OW(BYTE_W)) u_ea_add (
        .base_i (sel_val),
        .off_i  (off),
        .sum_o  (ea_sum)
    );

    ptr_page_adder #(.AW(ADDR_W), .PW(PAGE_W), .OW(BYTE_W)) u_pc_add (
        .base_i (st_q.ptr[0]),
        .off_i  (ONE),
        .sum_o  (pc_step)
    );

    ptr_op_arbiter u_arb (
        .xchg_pc_i   (xchg_pc_i),
        .xchg_byte_i (xchg_byte_i),
        .auto_idx_i  (auto_idx_i),
        .pc_inc_i    (pc_inc_i),
        .op_o        (op)
    );

    assign post_mode = auto_idx_i && !off[BYTE_W-1];
    assign ea_o      = post_mode ? sel_val : ea_sum;
    assign acc_o     = byte_hi_i ? sel_val[ADDR_W-1:ADDR_W-BYTE_W]
                                 : sel_val[BYTE_W-1:0];

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_XPC: begin
                st_d.ptr[ptr_sel] = st_q.ptr[0];
                st_d.ptr[0]       = sel_val;
            end
            OP_XBYTE: begin
                if (byte_hi_i)
                    st_d.ptr[ptr_sel][ADDR_W-1:ADDR_W-BYTE_W] = acc_i;
                else
                    st_d.ptr[ptr_sel][BYTE_W-1:0] = acc_i;
            end
            OP_AUTO: st_d.ptr[ptr_sel] = ea_sum;
            OP_INC:  st_d.ptr[0]       = pc_step;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o = st_q.ptr[0];
    assign p1_o = st_q.ptr[1];
    assign p2_o = st_q.ptr[2];
    assign p3_o = st_q.ptr[3];
endmodule

// File: rtl/ptr_page_eau_chk.sv
module ptr_page_eau_chk
    import ptr_page_eau_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [SEL_W-1:0]   ptr_sel,
    input logic [BYTE_W-1:0]  disp_i,
    input logic               xchg_pc_i,
    input logic               xchg_byte_i,
    input logic               auto_idx_i,
    input logic               pc_inc_i,
    input logic [ADDR_W-1:0]  ea_o,
    input logic [ADDR_W-1:0]  pc_o,
    input logic [ADDR_W-1:0]  p1_o,
    input logic [ADDR_W-1:0]  p2_o,
    input logic [ADDR_W-1:0]  p3_o
);
    logic [ADDR_W-1:0] cur;
    logic              idle;
    logic              step_only;

    always_comb begin
        case (ptr_sel)
            2'd0:    cur = pc_o;
            2'd1:    cur = p1_o;
            2'd2:    cur = p2_o;
            default: cur = p3_o;
        endcase
    end

    assign idle      = !xchg_pc_i && !xchg_byte_i && !auto_idx_i && !pc_inc_i;
    assign step_only = pc_inc_i && !xchg_pc_i && !xchg_byte_i && !auto_idx_i;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && p1_o == '0 && p2_o == '0 && p3_o == '0)); // R1

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ea_o[ADDR_W-1:PAGE_W] == cur[ADDR_W-1:PAGE_W]); // R2

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step_only |=> pc_o == {$past(pc_o[ADDR_W-1:PAGE_W]),
                               $past(pc_o[PAGE_W-1:0]) + PAGE_W'(1)}); // R4

    AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_idx_i && !disp_i[BYTE_W-1]) |-> ea_o == cur); // R6

    AST_XPC_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_pc_i |=> pc_o == $past(cur)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> ($stable(pc_o) && $stable(p1_o) && $stable(p2_o) && $stable(p3_o))); // R10
endmodule

bind ptr_page_eau ptr_page_eau_chk u_chk (.*);

// File: tb/ptr_page_eau_bench.sv
`timescale 1ns/1ps
module ptr_page_eau_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [7:0]  disp_i = '0, ext_i = '0, acc_i = '0;
    logic        xchg_pc_i = 0, xchg_byte_i = 0, byte_hi_i = 0, auto_idx_i = 0, pc_inc_i = 0;
    logic [15:0] ea_o, pc_o, p1_o, p2_o, p3_o;
    logic [7:0]  acc_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] mp [4];
    string prev_tag = "R1";

    always #5 clk = ~clk;

    ptr_page_eau u_ptr_page_eau (
        .clk(clk), .rst_n(rst_n), .ptr_sel(ptr_sel), .disp_i(disp_i),
        .ext_i(ext_i), .acc_i(acc_i), .xchg_pc_i(xchg_pc_i),
        .xchg_byte_i(xchg_byte_i), .byte_hi_i(byte_hi_i),
        .auto_idx_i(auto_idx_i), .pc_inc_i(pc_inc_i), .ea_o(ea_o),
        .acc_o(acc_o), .pc_o(pc_o), .p1_o(p1_o), .p2_o(p2_o), .p3_o(p3_o)
    );

    function automatic int offv(logic [7:0] d, logic [7:0] e);
        logic [7:0] v;
        v = (d == 8'h80) ? e : d;
        return v[7] ? int'(v) - 256 : int'(v);
    endfunction

    function automatic logic [15:0] padd(logic [15:0] b, int o);
        int low;
        low = (int'(b[11:0]) + o) & 32'h0FFF;
        return {b[15:12], low[11:0]};
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_ptrs(string tag);
        chk(tag, "pc", pc_o, mp[0]);
        chk(tag, "p1", p1_o, mp[1]);
        chk(tag, "p2", p2_o, mp[2]);
        chk(tag, "p3", p3_o, mp[3]);
    endtask

    task automatic step(string tag, logic [1:0] s, logic [7:0] d, logic [7:0] e,
                        logic [7:0] a, logic xp, logic xb, logic hi, logic au, logic inc);
        int o;
        logic [15:0] eff, exp_ea, tmp;
        @(negedge clk);
        ptr_sel = s; disp_i = d; ext_i = e; acc_i = a;
        xchg_pc_i = xp; xchg_byte_i = xb; byte_hi_i = hi; auto_idx_i = au; pc_inc_i = inc;
        #1;
        check_ptrs(prev_tag);
        o = offv(d, e);
        eff = padd(mp[s], o);
        exp_ea = (au && o >= 0) ? mp[s] : eff;
        chk(tag, "ea", ea_o, exp_ea);
        chk("R7", "acc_o", {8'h00, acc_o}, {8'h00, hi ? mp[s][15:8] : mp[s][7:0]});
        if (xp) begin
            tmp = mp[s]; mp[s] = mp[0]; mp[0] = tmp;
        end else if (xb) begin
            if (hi) mp[s][15:8] = a; else mp[s][7:0] = a;
        end else if (au) begin
            mp[s] = eff;
        end else if (inc) begin
            mp[0] = padd(mp[0], 1);
        end
        prev_tag = tag;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (mp[i]) mp[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        check_ptrs("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R7: load p1 = 0x1FF0 through byte swaps
        step("R7", 2'd1, 8'h00, 8'h00, 8'h1F, 0, 1, 1, 0, 0);
        step("R7", 2'd1, 8'h00, 8'h00, 8'hF0, 0, 1, 0, 0, 0);
        // R2: forward page wrap 0x1FF0 + 0x20 -> 0x1010; R10 idle
        step("R2", 2'd1, 8'h20, 8'h00, 8'h00, 0, 0, 0, 0, 0);
        step("R10", 2'd1, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0);
        // R6: post-increment
        step("R6", 2'd1, 8'h20, 8'h00, 8'h00, 0, 0, 0, 1, 0);
        // R5: pre-decrement, then backward wrap 0x1000 - 1 -> 0x1FFF
        step("R5", 2'd1, 8'hF0, 8'h00, 8'h00, 0, 0, 0, 1, 0);
        step("R5", 2'd1, 8'hFF, 8'h00, 8'h00, 0, 0, 0, 1, 0);
        // R3: extension offset, positive and -128
        step("R3", 2'd1, 8'h80, 8'h02, 8'h00, 0, 0, 0, 0, 0);
        step("R3", 2'd1, 8'h80, 8'h80, 8'h00, 0, 0, 0, 0, 0);
        step("R3", 2'd1, 8'h80, 8'hFE, 8'h00, 0, 0, 0, 1, 0);
        // R8: load p2 = 0x2FFF and exchange into PC
        step("R7", 2'd2, 8'h00, 8'h00, 8'h2F, 0, 1, 1, 0, 0);
        step("R7", 2'd2, 8'h00, 8'h00, 8'hFF, 0, 1, 0, 0, 0);
        step("R8", 2'd2, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, 0);
        // R4: PC step wraps 0x2FFF -> 0x2000
        step("R4", 2'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1);
        step("R4", 2'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1);
        // R8: exchange with itself changes nothing
        step("R8", 2'd0, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, 0);
        // R9: strobe collisions
        step("R9", 2'd1, 8'h10, 8'h00, 8'h55, 1, 1, 1, 1, 1);
        step("R9", 2'd3, 8'h10, 8'h00, 8'hAA, 0, 1, 0, 1, 1);
        step("R9", 2'd3, 8'h10, 8'h00, 8'h00, 0, 0, 0, 1, 1);
        step("R9", 2'd0, 8'hF8, 8'h00, 8'h00, 0, 0, 0, 1, 1);
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] d, e, a;
            logic [1:0] s;
            logic xp, xb, hi, au, inc;
            string tag;
            s = 2'($urandom_range(0, 3));
            d = ($urandom_range(0, 7) == 0) ? 8'h80 : 8'($urandom);
            e = 8'($urandom); a = 8'($urandom);
            xp = ($urandom_range(0, 9) == 0);
            xb = ($urandom_range(0, 5) == 0);
            hi = 1'($urandom);
            au = ($urandom_range(0, 2) == 0);
            inc = ($urandom_range(0, 1) == 0);
            if (xp)                  tag = "R8";
            else if (xb)             tag = "R7";
            else if (au && d[7])     tag = "R5";
            else if (au)             tag = "R6";
            else if (inc)            tag = "R4";
            else if (d == 8'h80)     tag = "R3";
            else                     tag = "R10";
            step(tag, s, d, e, a, xp, xb, hi, au, inc);
        end
        step("R10", 2'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule